// File: doc/BRIEF.md
# Default Data Capability Address Checker

This block checks a plain (non-capability) data address against the default data capability before the address reaches memory. A request carries a 64-bit offset, an access kind, an access width and an unaligned-access mode. The default capability arrives as already decoded fields: tag, sealed flag, load and store permissions, cursor, base, and a 65-bit top. The block adds the offset to the cursor with wrap-around to form the virtual address. It works out which bytes the access touches and tests them against the bounds. It returns either the virtual address or a fault cause, and every fault cause refers to capability register 0.

Requests and responses each use a valid/ready handshake, with a single register stage between them. A request is accepted when `req_valid` and `req_ready` are both high. The capability fields are sampled in the same cycle as the request. `req_ready` is high whenever the output stage is empty or is being drained in that cycle. A response is presented with `rsp_valid`, and it stays unchanged until `rsp_ready` takes it. Responses come out in the order the requests were accepted, one response for each request.

Top module: `ddc_addr_guard`

## Requirements
- R1: The virtual address is cursor + offset modulo 2^64. A request that passes every check returns that address on `rsp_addr` with cause 0 (none).
- R2: A clear tag gives cause 1 (tag fault), whatever the other capability fields hold.
- R3: A tagged but sealed capability gives cause 2 (seal fault). A tagged, unsealed capability used with access kind 2'b1x (instruction fetch, not legal on this path) gives cause 6.
- R4: A load (kind 2'b00) without load permission gives cause 3. A store (kind 2'b01) without store permission gives cause 4. The permission that does not belong to the access kind has no effect.
- R5: An aligned access (mode 3'b000, or any unused mode 3'b101 to 3'b111) spans 2^width bytes from the address, for width 0 to 3. It gives cause 5 (length fault) when address + size exceeds top. The comparison uses 65-bit arithmetic, so an access that ends exactly at top passes, and a top of 2^64 is usable.
- R6: An access whose first touched byte lies below base gives cause 5.
- R7: Word-left (mode 3'b001) spans from the address with size 4 − (addr mod 4). Word-right (mode 3'b010) spans from addr − (addr mod 4) with size (addr mod 4) + 1. The width input is ignored in these modes.
- R8: Doubleword-left (3'b011) and doubleword-right (3'b100) use the same rule as R7 with granule 8.
- R9: For the four unaligned modes, a passing request returns the unmodified virtual address, not the start of the span.
- R10: The fault priority is tag, then seal, then illegal kind, then permission, then length. A faulting response has `rsp_addr` = 0, and `rsp_reg` is 0 on every response.
- R11: `req_ready` = !`rsp_valid` | `rsp_ready`. A response held under back-pressure keeps its address and cause stable. Each accepted request yields exactly one response on the next cycle's output, in order.
- R12: After reset `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_offset | input | 64 | Address offset from the cursor |
| req_kind | input | 2 | 00 load, 01 store, 1x fetch (illegal) |
| req_width | input | 2 | Aligned size is 2^width bytes |
| req_mode | input | 3 | 000 aligned, 001 word-left, 010 word-right, 011 dword-left, 100 dword-right |
| cap_tag | input | 1 | Capability tag valid |
| cap_sealed | input | 1 | Capability sealed |
| cap_perm_load | input | 1 | Load permitted |
| cap_perm_store | input | 1 | Store permitted |
| cap_cursor | input | 64 | Capability cursor |
| cap_base | input | 64 | Lower bound |
| cap_top | input | 65 | Upper bound (exclusive) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | 64 | Virtual address, or 0 on fault |
| rsp_cause | output | 3 | 0 none, 1 tag, 2 seal, 3 load perm, 4 store perm, 5 length, 6 illegal kind |
| rsp_reg | output | 5 | Register the fault refers to (always 0) |

## Verification
Draining a held response and accepting a new request can happen in the same cycle, and this is the case that matters most. The bench provokes it by first holding `rsp_ready` low while one result sits in the output stage. It then presents a second request and confirms that `req_ready` stays low and the held result does not change. Next it raises `rsp_ready` so that the drain and the accept happen on one edge. The check passes when the next response is the second request's result and the first result is neither lost nor repeated.

// File: rtl/ddc_guard_pkg.sv
package ddc_guard_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_TAG        = 3'd1,
    CAUSE_SEAL       = 3'd2,
    CAUSE_LOAD_PERM  = 3'd3,
    CAUSE_STORE_PERM = 3'd4,
    CAUSE_LENGTH     = 3'd5,
    CAUSE_BAD_KIND   = 3'd6
  } cause_e;

  typedef enum logic [2:0] {
    MODE_ALIGNED = 3'd0,
    MODE_WORD_L  = 3'd1,
    MODE_WORD_R  = 3'd2,
    MODE_DWORD_L = 3'd3,
    MODE_DWORD_R = 3'd4
  } mode_e;

  localparam logic [1:0] KIND_LOAD  = 2'b00;
  localparam logic [1:0] KIND_STORE = 2'b01;
endpackage

// File: rtl/ddc_span.sv
module ddc_span #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_G = 4,
  parameter int SIZE_W   = 4
) (
  input  logic [ADDR_W-1:0] cursor,
  input  logic [ADDR_W-1:0] offset,
  input  logic [1:0]        width,
  input  logic [2:0]        mode,
  output logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] span_start,
  output logic [SIZE_W-1:0] span_size
);
  import ddc_guard_pkg::*;

  localparam int NUM_G = 2;

  logic [ADDR_W-1:0] r_start [NUM_G];
  logic [SIZE_W-1:0] l_size  [NUM_G];
  logic [SIZE_W-1:0] r_size  [NUM_G];

  assign vaddr = cursor + offset;

  // one left/right span pair per granule (narrow, then twice as wide)
  for (genvar g = 0; g < NUM_G; g++) begin : g_gran
    localparam int GRAN = NARROW_G << g;
    localparam int LOGG = $clog2(GRAN);
    logic [LOGG-1:0] low;
    assign low        = vaddr[LOGG-1:0];
    assign l_size[g]  = SIZE_W'(GRAN) - SIZE_W'(low);
    assign r_size[g]  = SIZE_W'(low) + SIZE_W'(1);
    assign r_start[g] = {vaddr[ADDR_W-1:LOGG], {LOGG{1'b0}}};
  end

  always_comb begin
    span_start = vaddr;
    span_size  = SIZE_W'(1) << width;
    case (mode)
      MODE_WORD_L:  span_size = l_size[0];
      MODE_WORD_R: begin
        span_start = r_start[0];
        span_size  = r_size[0];
      end
      MODE_DWORD_L: span_size = l_size[1];
      MODE_DWORD_R: begin
        span_start = r_start[1];
        span_size  = r_size[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddc_bounds.sv
module ddc_bounds #(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] span_start,
  input  logic [SIZE_W-1:0] span_size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W:0]   top,
  output logic              out_of_bounds
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] span_end;

  assign span_end      = {1'b0, span_start} + EXT_W'(span_size);
  assign out_of_bounds = (span_end > top) || (span_start < base);
endmodule

// File: rtl/ddc_fault_pri.sv
module ddc_fault_pri (
  input  logic       tag,
  input  logic       sealed,
  input  logic [1:0] kind,
  input  logic       perm_load,
  input  logic       perm_store,
  input  logic       out_of_bounds,
  output ddc_guard_pkg::cause_e cause
);
  import ddc_guard_pkg::*;

  always_comb begin
    if (!tag)                                  cause = CAUSE_TAG;
    else if (sealed)                           cause = CAUSE_SEAL;
    else if (kind[1])                          cause = CAUSE_BAD_KIND;
    else if (kind == KIND_LOAD && !perm_load)  cause = CAUSE_LOAD_PERM;
    else if (kind == KIND_STORE && !perm_store) cause = CAUSE_STORE_PERM;
    else if (out_of_bounds)                    cause = CAUSE_LENGTH;
    else                                       cause = CAUSE_NONE;
  end
endmodule

// File: rtl/ddc_addr_guard.sv
module ddc_addr_guard #(
  parameter int ADDR_W   = 64,
  parameter int REG_W    = 5,
  parameter int NARROW_G = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_width,
  input  logic [2:0]        req_mode,
  input  logic              cap_tag,
  input  logic              cap_sealed,
  input  logic              cap_perm_load,
  input  logic              cap_perm_store,
  input  logic [ADDR_W-1:0] cap_cursor,
  input  logic [ADDR_W-1:0] cap_base,
  input  logic [ADDR_W:0]   cap_top,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [2:0]        rsp_cause,
  output logic [REG_W-1:0]  rsp_reg
);
  import ddc_guard_pkg::*;

  localparam int WIDE_G = NARROW_G * 2;
  localparam int SIZE_W = $clog2(WIDE_G) + 1;

  logic [ADDR_W-1:0] vaddr;
  logic [ADDR_W-1:0] span_start;
  logic [SIZE_W-1:0] span_size;
  logic              oob;
  cause_e            cause;
  logic              fire;

  ddc_span #(.ADDR_W(ADDR_W), .NARROW_G(NARROW_G), .SIZE_W(SIZE_W)) u_span (
    .cursor(cap_cursor), .offset(req_offset), .width(req_width), .mode(req_mode),
    .vaddr(vaddr), .span_start(span_start), .span_size(span_size)
  );

  ddc_bounds #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bounds (
    .span_start(span_start), .span_size(span_size), .base(cap_base),
    .top(cap_top), .out_of_bounds(oob)
  );

  ddc_fault_pri u_pri (
    .tag(cap_tag), .sealed(cap_sealed), .kind(req_kind),
    .perm_load(cap_perm_load), .perm_store(cap_perm_store),
    .out_of_bounds(oob), .cause(cause)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rsp_reg   = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (fire) begin
        rsp_cause <= cause;
        rsp_addr  <= (cause == CAUSE_NONE) ? vaddr : '0;
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_cause));

  // R11
  accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R10
  fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_cause != CAUSE_NONE |-> rsp_addr == '0);

  // R2
  tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cap_tag |=> rsp_cause == CAUSE_TAG);

  // R7
  span_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> span_start <= vaddr &&
      ({1'b0, span_start} + (ADDR_W+1)'(span_size)) > {1'b0, vaddr});
endmodule

// File: tb/ddc_addr_guard_bench.sv
module ddc_addr_guard_bench;
  typedef struct packed {
    logic [63:0] cur;
    logic [63:0] off;
    logic [63:0] base;
    logic [64:0] top;
    logic [1:0]  kind;
    logic [1:0]  width;
    logic [2:0]  mode;
    logic        tag;
    logic        sealed;
    logic        pl;
    logic        ps;
    logic [2:0]  cause;
    logic [63:0] addr;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam logic [64:0] TOP_MAX = 65'h1_0000_0000_0000_0000;
  localparam vec_t VECS [NV] = '{
    // R1 plain load passes
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1020, 4'd1},
    // R1 cursor + offset wraps
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h18, 64'h0, 65'h100, 2'd0, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h8, 4'd1},
    // R2 clear tag beats seal and perm
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 64'h0, 4'd2},
    // R3 sealed
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 64'h0, 4'd3},
    // R3 fetch kind illegal
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd2, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 64'h0, 4'd3},
    // R4 load w/o load perm
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 64'h0, 4'd4},
    // R4 store w/o store perm
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd1, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 64'h0, 4'd4},
    // R4 store ignores missing load perm
    '{64'h1000, 64'h20, 64'h1000, 65'h2000, 2'd1, 2'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 64'h1020, 4'd4},
    // R5 exact fit at top
    '{64'h1000, 64'hFF8, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1FF8, 4'd5},
    // R5 past top
    '{64'h1000, 64'hFFC, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd5},
    // R5 top of 2^64
    '{64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 64'h0, TOP_MAX, 2'd0, 2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFF8, 4'd5},
    // R6 below base
    '{64'h1000, 64'h0, 64'h1001, 65'h2000, 2'd0, 2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd6},
    // R7 word-left fits where aligned word would not
    '{64'h1000, 64'hFFE, 64'h1000, 65'h2000, 2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1FFE, 4'd7},
    // R7 word-left past top
    '{64'h1000, 64'hFFE, 64'h1000, 65'h1FFF, 2'd0, 2'd2, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd7},
    // R7 word-right start below base
    '{64'h1000, 64'h3, 64'h1001, 65'h2000, 2'd0, 2'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd7},
    // R9 word-right passes, unmodified address
    '{64'h1000, 64'h3, 64'h1000, 65'h1004, 2'd0, 2'd2, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1003, 4'd9},
    // R8 dword-left fits
    '{64'h1000, 64'hFFB, 64'h1000, 65'h2000, 2'd0, 2'd3, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1FFB, 4'd8},
    // R8 dword-right start below base
    '{64'h1000, 64'h5, 64'h1001, 65'h2000, 2'd0, 2'd3, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd8},
    // R9 dword-right passes, unmodified address
    '{64'h1000, 64'h5, 64'h1000, 65'h1006, 2'd0, 2'd3, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 64'h1005, 4'd9},
    // R8 dword-left past top
    '{64'h1000, 64'hFFB, 64'h1000, 65'h1FFF, 2'd0, 2'd3, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd8},
    // R5 halfword crosses top
    '{64'h1000, 64'hFFF, 64'h1000, 65'h2000, 2'd0, 2'd1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 64'h0, 4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_offset = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_width = '0;
  logic [2:0]  req_mode = '0;
  logic        cap_tag = 1'b0;
  logic        cap_sealed = 1'b0;
  logic        cap_perm_load = 1'b0;
  logic        cap_perm_store = 1'b0;
  logic [63:0] cap_cursor = '0;
  logic [63:0] cap_base = '0;
  logic [64:0] cap_top = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_cause;
  logic [4:0]  rsp_reg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ddc_addr_guard u_ddc_addr_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_kind(req_kind), .req_width(req_width),
    .req_mode(req_mode), .cap_tag(cap_tag), .cap_sealed(cap_sealed),
    .cap_perm_load(cap_perm_load), .cap_perm_store(cap_perm_store),
    .cap_cursor(cap_cursor), .cap_base(cap_base), .cap_top(cap_top),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_cause(rsp_cause), .rsp_reg(rsp_reg)
  );

  task automatic drive(input vec_t v);
    req_valid      = 1'b1;
    req_offset     = v.off;
    req_kind       = v.kind;
    req_width      = v.width;
    req_mode       = v.mode;
    cap_tag        = v.tag;
    cap_sealed     = v.sealed;
    cap_perm_load  = v.pl;
    cap_perm_store = v.ps;
    cap_cursor     = v.cur;
    cap_base       = v.base;
    cap_top        = v.top;
  endtask

  task automatic expect_rsp(input vec_t v, input string tag);
    checks++;
    if (!rsp_valid || rsp_addr !== v.addr || rsp_cause !== v.cause || rsp_reg !== 5'd0) begin
      errors++;
      $display("FAIL %s (R%0d): valid=%0b addr=%h cause=%0d reg=%0d, expected valid=1 addr=%h cause=%0d reg=0",
               tag, v.rq, rsp_valid, rsp_addr, rsp_cause, rsp_reg, v.addr, v.cause);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R12 rsp_valid after reset");
    check_bit(req_ready, 1'b1, "R12 req_ready after reset");

    // vector table, one request per cycle, response checked next cycle
    drive(VECS[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      expect_rsp(VECS[i], "table");
      if (i + 1 < NV) drive(VECS[i + 1]);
      else req_valid = 1'b0;
    end
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R11 no extra response");

    // back-pressure: hold result A, then drain A and accept B on one edge
    rsp_ready = 1'b0;
    drive(VECS[0]);
    @(negedge clk);
    expect_rsp(VECS[0], "R11 A presented");
    drive(VECS[2]);
    check_bit(req_ready, 1'b0, "R11 ready low while held");
    @(negedge clk);
    expect_rsp(VECS[0], "R11 A held stable");
    check_bit(req_ready, 1'b0, "R11 B still stalled");
    rsp_ready = 1'b1;
    @(negedge clk);
    expect_rsp(VECS[2], "R11 B follows A");
    req_valid = 1'b0;
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R11 B delivered once");

    // reset mid-stream clears the output stage
    drive(VECS[1]);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R12 reset clears response");
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule